// File: doc/BRIEF.md
# Toggle Handshake Clock-Domain Crossing

This block carries one multi-bit word at a time from a transmit clock domain to a receive clock domain whose clock has no fixed relation to the first. Each transfer costs one edge of a request level and one edge of an acknowledge level, with no return-to-zero phase. Only those two single-bit levels cross between the domains, and each one passes through a two-flop synchronizer clocked by its destination. The data bus is never synchronized. The sender holds the bus steady for the whole time a transfer is outstanding, so the receiver can sample it safely.

On the sending side a word is offered through a valid/ready pair. The word is accepted on a clock edge where both are high. The block then holds the word on its internal bus, inverts the request and drops ready until the acknowledge comes back. On the receiving side a transfer is pending whenever the synchronized request differs from the local acknowledge. The receiver then captures the bus, copies the synchronized request into the acknowledge, and presents the word with a one-cycle valid pulse. Each domain has its own active-low reset. The reset is asserted asynchronously and released in step with that domain's clock.

Top module: `toggle_hs_cdc`

## Requirements
- R1: After reset, and whenever no transfer is outstanding, `tx_ready_o` is 1. On the cycle after a word is accepted (`tx_valid_i` and `tx_ready_o` both 1 at a transmit clock edge), `tx_ready_o` is 0. It stays 0 until the acknowledge returns.
- R2: While `tx_ready_o` is 0, a high `tx_valid_i` has no effect. The held word and the request level do not change, and no extra word is delivered.
- R3: The request reaches the receive logic only through two receive-clock flops. The first `rx_valid_o` pulse for an accepted word is observed at the 3rd to 5th receive clock falling edge after the accepting transmit edge.
- R4: When a transfer is pending, the receiver captures the bus and sets its acknowledge equal to the synchronized request. It raises `rx_valid_o` for exactly one receive cycle with `rx_data_o` equal to the accepted word.
- R5: The acknowledge reaches the transmit logic only through two transmit-clock flops. `tx_ready_o` is 1 again within 4 transmit cycles after the `rx_valid_o` pulse is seen.
- R6: Every accepted word is delivered exactly once and in acceptance order, whatever the ratio and phase of the two clocks, and with any gaps between offers.
- R7: While either reset is low, and just after release, `rx_valid_o` is 0, `rx_data_o` is 0 and `tx_ready_o` is 1. The request, the acknowledge and all synchronizer flops are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk_i | input | 1 | Transmit domain clock |
| tx_rst_ni | input | 1 | Transmit domain active-low reset |
| tx_valid_i | input | 1 | Word offered for transfer |
| tx_data_i | input | DATA_W | Offered word |
| tx_ready_o | output | 1 | Block can accept a word this cycle |
| rx_clk_i | input | 1 | Receive domain clock |
| rx_rst_ni | input | 1 | Receive domain active-low reset |
| rx_valid_o | output | 1 | One-cycle pulse marking a delivered word |
| rx_data_o | output | DATA_W | Delivered word |

## Verification
An accepted word appears at the receiver after two synchronizer flops and one capture register. The bench counts receive falling edges from the accepting transmit edge and expects the pulse at edge 3, 4 or 5. The extra edge covers the unknown phase, including edges that coincide. Ready returns after the acknowledge crosses two transmit flops, and the bench expects it within 4 transmit falling edges of the pulse. All other sampling happens on falling edges. Ordering and uniqueness are checked at every pulse against a queue of accepted words, under several receive periods that are faster than, slower than and equal to the transmit clock.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  parameter int unsigned SYNC_STAGES = 2;
  parameter int unsigned RST_STAGES  = 2;
endpackage

// File: rtl/cdc_rst_sync.sv
module cdc_rst_sync #(
  parameter int unsigned STAGES = cdc_pkg::RST_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/cdc_bit_sync.sv
module cdc_bit_sync #(
  parameter int unsigned STAGES = cdc_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/cdc_tx_ctrl.sv
module cdc_tx_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  input  logic              ack_sync_i,
  output logic              req_o,
  output logic [DATA_W-1:0] bus_o
);
  logic              req_q;
  logic [DATA_W-1:0] bus_q;
  logic              accept;

  assign ready_o = (req_q == ack_sync_i);
  assign accept  = valid_i && ready_o;

  // request flips and new word loads in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      bus_q <= '0;
    end else if (accept) begin
      req_q <= ~req_q;
      bus_q <= data_i;
    end
  end

  assign req_o = req_q;
  assign bus_o = bus_q;

  assert_busy_after_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);
  assert_bus_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(bus_q));
  assert_req_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(req_q));
endmodule

// File: rtl/cdc_rx_ctrl.sv
module cdc_rx_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_sync_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              ack_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              ack_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              pending;

  assign pending = (req_sync_i != ack_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= pending;
      if (pending) begin
        ack_q  <= req_sync_i;
        data_q <= bus_i;
      end
    end
  end

  assign ack_o   = ack_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_ack_toggled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> (ack_q != $past(ack_q)));
endmodule

// File: rtl/toggle_hs_cdc.sv
module toggle_hs_cdc #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              tx_clk_i,
  input  logic              tx_rst_ni,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  input  logic              rx_clk_i,
  input  logic              rx_rst_ni,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic              tx_rst_n, rx_rst_n;
  logic              req, req_sync, ack, ack_sync;
  logic [DATA_W-1:0] bus;

  cdc_rst_sync u_tx_rst (.clk_i(tx_clk_i), .rst_ni(tx_rst_ni), .rst_no(tx_rst_n));
  cdc_rst_sync u_rx_rst (.clk_i(rx_clk_i), .rst_ni(rx_rst_ni), .rst_no(rx_rst_n));

  cdc_tx_ctrl #(.DATA_W(DATA_W)) u_tx (
    .clk_i(tx_clk_i), .rst_ni(tx_rst_n), .valid_i(tx_valid_i), .data_i(tx_data_i),
    .ready_o(tx_ready_o), .ack_sync_i(ack_sync), .req_o(req), .bus_o(bus)
  );

  cdc_bit_sync u_req_sync (.clk_i(rx_clk_i), .rst_ni(rx_rst_n), .d_i(req), .q_o(req_sync));

  // bus crosses unsynchronized: held stable while a transfer is outstanding
  cdc_rx_ctrl #(.DATA_W(DATA_W)) u_rx (
    .clk_i(rx_clk_i), .rst_ni(rx_rst_n), .req_sync_i(req_sync), .bus_i(bus),
    .ack_o(ack), .valid_o(rx_valid_o), .data_o(rx_data_o)
  );

  cdc_bit_sync u_ack_sync (.clk_i(tx_clk_i), .rst_ni(tx_rst_n), .d_i(ack), .q_o(ack_sync));
endmodule

// File: tb/toggle_hs_cdc_bench.sv
`timescale 1ns/1ps
module toggle_hs_cdc_bench;
  localparam int W = 8;

  logic tx_clk = 0, rx_clk = 0;
  logic tx_rst_n = 0, rx_rst_n = 0;
  logic tx_valid = 0;
  logic [W-1:0] tx_data = '0;
  logic tx_ready, rx_valid;
  logic [W-1:0] rx_data;
  realtime rx_half = 3.7;

  int vectors = 0, errors = 0, delivered = 0;
  logic [W-1:0] exp_q[$];

  always #2.5 tx_clk = ~tx_clk;
  always #(rx_half) rx_clk = ~rx_clk;

  toggle_hs_cdc #(.DATA_W(W)) u_toggle_hs_cdc (
    .tx_clk_i(tx_clk), .tx_rst_ni(tx_rst_n), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .tx_ready_o(tx_ready), .rx_clk_i(rx_clk), .rx_rst_ni(rx_rst_n),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard: R6 order and uniqueness, R4 one pulse per word
  always @(negedge rx_clk) begin
    if (rx_valid) begin
      delivered++;
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected word", int'(rx_data), -1);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R6 order", int'(rx_data), int'(e));
      end
    end
  end

  task automatic send(input logic [W-1:0] w);
    @(negedge tx_clk);
    while (!tx_ready) @(negedge tx_clk);
    tx_valid = 1; tx_data = w;
    exp_q.push_back(w);
    @(negedge tx_clk);
    tx_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && (exp_q.size() != 0 || !tx_ready); i++) @(negedge tx_clk);
    check(exp_q.size() == 0, "R6 all delivered", exp_q.size(), 0);
  endtask

  task automatic t_reset();
    tx_rst_n = 0; rx_rst_n = 0;
    repeat (4) @(negedge tx_clk);
    check(tx_ready == 1, "R7 ready in reset", tx_ready, 1);
    check(rx_valid == 0, "R7 valid in reset", rx_valid, 0);
    check(rx_data == 0, "R7 data in reset", rx_data, 0);
    tx_rst_n = 1; rx_rst_n = 1;
    repeat (6) @(negedge tx_clk);
    check(tx_ready == 1, "R7 ready after release", tx_ready, 1);
    check(rx_valid == 0 && delivered == 0, "R7 no spurious word", delivered, 0);
  endtask

  task automatic t_single(input logic [W-1:0] w);
    int n = 0, m = 0, d0;
    @(negedge tx_clk);
    while (!tx_ready) @(negedge tx_clk);
    check(tx_ready == 1, "R1 ready when idle", tx_ready, 1);
    d0 = delivered;
    tx_valid = 1; tx_data = w; exp_q.push_back(w);
    @(posedge tx_clk);
    fork
      begin
        @(negedge tx_clk); tx_valid = 0;
        check(tx_ready == 0, "R1 busy after accept", tx_ready, 0);
      end
      begin
        do begin @(negedge rx_clk); n++; end while (!rx_valid && n < 20);
      end
    join
    check(n >= 3 && n <= 5, "R3 request latency", n, 4);
    check(rx_data == w, "R4 captured word", int'(rx_data), int'(w));
    @(negedge rx_clk);
    check(rx_valid == 0, "R4 single pulse", rx_valid, 0);
    while (!tx_ready && m < 20) begin @(negedge tx_clk); m++; end
    check(m <= 4, "R5 ack return latency", m, 4);
    check(delivered == d0 + 1, "R4 one delivery", delivered - d0, 1);
  endtask

  task automatic t_ignore_busy(input logic [W-1:0] w, input logic [W-1:0] junk);
    int d0 = delivered;
    send(w);
    // offer junk only while busy
    while (!tx_ready) begin
      tx_valid = 1; tx_data = junk;
      @(negedge tx_clk);
    end
    tx_valid = 0;
    repeat (30) @(negedge tx_clk);
    check(delivered == d0 + 1, "R2 busy offer ignored", delivered - d0, 1);
    check(rx_data == w, "R2 held word delivered", int'(rx_data), int'(w));
  endtask

  task automatic t_stream(input realtime half, input int words);
    int d0;
    rx_half = half;
    repeat (10) @(negedge tx_clk);
    d0 = delivered;
    for (int i = 0; i < words; i++) begin
      send(W'($urandom));
      repeat ($urandom_range(0, 5)) @(negedge tx_clk);
    end
    drain();
    check(delivered - d0 == words, "R6 count", delivered - d0, words);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(17));
    t_reset();
    t_single(8'hA5);
    t_single(8'h00);
    t_single(8'hFF);
    t_ignore_busy(8'h3C, 8'hEE);
    t_stream(3.7, 40);
    t_stream(11.3, 40);
    t_stream(2.5, 40);
    t_stream(0.95, 40);
    rx_half = 6.1;
    repeat (10) @(negedge tx_clk);
    t_single(8'h81);
    t_ignore_busy(8'h5A, 8'h11);
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule